// File: doc/BRIEF.md
# Triangle LFO Modulation Source

This block is the low-frequency oscillator of an FM synthesis channel. It holds a 32-bit fixed-point phase counter whose top 7 bits form a step index. Each time the sample strobe arrives with the oscillator enabled, the counter advances by a programmable step. When the index moves, the block recomputes two values: an amplitude-modulation level that traces a folded triangle, and a coarse phase-modulation index.

The block also turns the amplitude level into an attenuation offset for each of four operators. An operator gets a non-zero offset only while the oscillator is enabled and that operator's mask bit is set. The size of the offset is scaled by a 2-bit sensitivity code. The channel's envelope path adds these offsets to each operator's attenuation. Applying the phase-modulation index to the phase generators is done elsewhere.

Top module: `lfo_tri_mod`

## Requirements
- R1: After reset, am_o, pm_o and every am_ofs_o lane are zero, and the internal counter is zero.
- R2: On a clock edge where sample_i and enable_i are both high, the counter becomes (counter + step_i) mod 2^32. The step index is counter bits [31:25]. am_o and pm_o show the result of the new index in the next cycle.
- R3: For step index n, am_o is 2*(n & 63) when n < 64. Otherwise it is 2*(63 - (n & 63)). am_o is therefore always even and at most 126.
- R4: pm_o is the step index divided by 4, taking bits [6:2] of the index, so its range is 0 to 31.
- R5: While enable_i is low, sample_i has no effect. The counter, am_o and pm_o hold their values.
- R6: am_ofs_o lane k equals am_o shifted right by a shift chosen by ams_i: code 0 gives 0 (the lane is zero), code 1 shifts by 3, code 2 shifts by 1, and code 3 shifts by 0. This holds when enable_i is high and am_mask_i[k] is 1.
- R7: A lane whose am_mask_i bit is 0 outputs zero, whatever the other lanes and inputs are.
- R8: While enable_i is low, every am_ofs_o lane is zero.
- R9: The counter wraps modulo 2^32, so the step index runs from 127 back to 0 and am_o returns to 0.
- R10: With sample_i low, am_o and pm_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Oscillator enable |
| sample_i | input | 1 | One-cycle strobe that advances the counter by one sample |
| step_i | input | 32 | Counter increment per sample (7.25 fixed point) |
| ams_i | input | 2 | Amplitude sensitivity code |
| am_mask_i | input | 4 | Per-operator amplitude-modulation enable |
| am_o | output | 7 | Doubled triangle amplitude level |
| pm_o | output | 5 | Phase-modulation index (step index / 4) |
| am_ofs_o | output | 4x7 | Per-operator attenuation offset, lane k in bits [7k+6:7k] |

## Verification
The bench walks the step index one value per sample through all 128 positions and past the wrap. An unfolded triangle would keep rising past index 63, an off-by-one fold would show 128 or an odd level, and a missing wrap would leave the output stuck near the top. Small steps that stay inside one index must leave both outputs unchanged. Large steps that skip several indices catch a divide-by-4 that counts index changes instead of dividing. Strobes sent while the oscillator is disabled must not move the counter: a design that advances it anyway gives a different index when it is enabled again. Each sensitivity code is tried with mixed masks, which catches a swapped shift table or lanes tied to the wrong mask bit.

// File: rtl/lfo_pkg.sv
package lfo_pkg;
  typedef enum logic [1:0] {
    AMS_NONE = 2'd0,
    AMS_LOW  = 2'd1,
    AMS_MID  = 2'd2,
    AMS_FULL = 2'd3
  } ams_e;

  // right shift applied to the AM level; NONE shifts out every bit
  function automatic int ams_shift(ams_e code, int am_w);
    case (code)
      AMS_NONE: return am_w;
      AMS_LOW:  return 3;
      AMS_MID:  return 1;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/lfo_phase_acc.sv
module lfo_phase_acc #(
  parameter int CNT_W = 32,
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] step_i,
  output logic [IDX_W-1:0] idx_cur_o,
  output logic [IDX_W-1:0] idx_nxt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_sum;

  assign cnt_sum   = cnt_q + step_i;  // wraps mod 2^CNT_W
  assign idx_cur_o = cnt_q[CNT_W-1 -: IDX_W];
  assign idx_nxt_o = cnt_sum[CNT_W-1 -: IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_sum;
  end
endmodule

// File: rtl/lfo_shape.sv
module lfo_shape #(
  parameter int IDX_W = 7,
  localparam int PM_W = IDX_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] idx_cur_i,
  input  logic [IDX_W-1:0] idx_nxt_i,
  output logic [IDX_W-1:0] am_o,
  output logic [PM_W-1:0]  pm_o
);
  logic [IDX_W-2:0] fold;
  logic [IDX_W-1:0] am_d;
  logic [PM_W-1:0]  pm_d;
  logic             am_upd, pm_upd;

  // upper half of the index counts back down
  assign fold   = idx_nxt_i[IDX_W-1] ? ~idx_nxt_i[IDX_W-2:0] : idx_nxt_i[IDX_W-2:0];
  assign am_d   = {fold, 1'b0};
  assign pm_d   = idx_nxt_i[IDX_W-1:2];
  assign am_upd = adv_i && (idx_nxt_i != idx_cur_i);
  assign pm_upd = adv_i && (pm_d != idx_cur_i[IDX_W-1:2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      am_o <= '0;
      pm_o <= '0;
    end else begin
      if (am_upd) am_o <= am_d;
      if (pm_upd) pm_o <= pm_d;
    end
  end
endmodule

// File: rtl/lfo_am_apply.sv
module lfo_am_apply
  import lfo_pkg::*;
#(
  parameter int AM_W  = 7,
  parameter int N_OPS = 4
) (
  input  logic                       enable_i,
  input  logic [1:0]                 ams_i,
  input  logic [N_OPS-1:0]           mask_i,
  input  logic [AM_W-1:0]            am_i,
  output logic [N_OPS-1:0][AM_W-1:0] ofs_o
);
  logic [AM_W-1:0] scaled;

  assign scaled = am_i >> ams_shift(ams_e'(ams_i), AM_W);

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    assign ofs_o[k] = (enable_i && mask_i[k]) ? scaled : '0;
  end
endmodule

// File: rtl/lfo_tri_mod.sv
module lfo_tri_mod #(
  parameter int CNT_W = 32,
  parameter int IDX_W = 7,
  parameter int N_OPS = 4,
  localparam int PM_W = IDX_W - 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        enable_i,
  input  logic                        sample_i,
  input  logic [CNT_W-1:0]            step_i,
  input  logic [1:0]                  ams_i,
  input  logic [N_OPS-1:0]            am_mask_i,
  output logic [IDX_W-1:0]            am_o,
  output logic [PM_W-1:0]             pm_o,
  output logic [N_OPS-1:0][IDX_W-1:0] am_ofs_o
);
  logic             adv;
  logic [IDX_W-1:0] idx_cur, idx_nxt;

  assign adv = sample_i && enable_i;

  lfo_phase_acc #(.CNT_W(CNT_W), .IDX_W(IDX_W)) i_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .step_i   (step_i),
    .idx_cur_o(idx_cur),
    .idx_nxt_o(idx_nxt)
  );

  lfo_shape #(.IDX_W(IDX_W)) i_shape (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .idx_cur_i(idx_cur),
    .idx_nxt_i(idx_nxt),
    .am_o     (am_o),
    .pm_o     (pm_o)
  );

  lfo_am_apply #(.AM_W(IDX_W), .N_OPS(N_OPS)) i_apply (
    .enable_i(enable_i),
    .ams_i   (ams_i),
    .mask_i  (am_mask_i),
    .am_i    (am_o),
    .ofs_o   (am_ofs_o)
  );
endmodule

// File: rtl/lfo_tri_mod_chk.sv
module lfo_tri_mod_chk #(
  parameter int IDX_W = 7,
  parameter int N_OPS = 4,
  localparam int PM_W = IDX_W - 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        enable_i,
  input logic                        sample_i,
  input logic [N_OPS-1:0]            am_mask_i,
  input logic [IDX_W-1:0]            am_o,
  input logic [PM_W-1:0]             pm_o,
  input logic [N_OPS-1:0][IDX_W-1:0] am_ofs_o
);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> $stable(am_o) && $stable(pm_o));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(am_o) && $stable(pm_o));

  p_even_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    am_o[0] == 1'b0);

  p_off_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> am_ofs_o == '0);

  for (genvar k = 0; k < N_OPS; k++) begin : g_lane
    p_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !am_mask_i[k] |-> am_ofs_o[k] == '0);
    p_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      am_ofs_o[k] <= am_o);
  end
endmodule

bind lfo_tri_mod lfo_tri_mod_chk #(.IDX_W(IDX_W), .N_OPS(N_OPS)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .sample_i (sample_i),
  .am_mask_i(am_mask_i),
  .am_o     (am_o),
  .pm_o     (pm_o),
  .am_ofs_o (am_ofs_o)
);

// File: tb/test_lfo_tri_mod.sv
module test_lfo_tri_mod;
  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            enable_i = 1'b0;
  logic            sample_i = 1'b0;
  logic [31:0]     step_i = '0;
  logic [1:0]      ams_i = '0;
  logic [3:0]      am_mask_i = '0;
  logic [6:0]      am_o;
  logic [4:0]      pm_o;
  logic [3:0][6:0] am_ofs_o;

  int total = 0, bad = 0;
  logic [31:0] m_cnt = '0;

  typedef struct {
    logic [6:0]      am;
    logic [4:0]      pm;
    logic [3:0][6:0] ofs;
    string           tag;
  } exp_t;
  exp_t q[$];

  always #5 clk_i = ~clk_i;

  lfo_tri_mod i_lfo_tri_mod (.*);

  function automatic logic [6:0] m_am(logic [6:0] n);
    return (n < 64) ? 7'((n & 63) * 2) : 7'((63 - (n & 63)) * 2);
  endfunction

  function automatic logic [3:0][6:0] m_ofs(logic [6:0] am, logic en,
                                           logic [1:0] s, logic [3:0] m);
    logic [3:0][6:0] r;
    logic [6:0] v;
    case (s)
      2'd0: v = 0;
      2'd1: v = am >> 3;
      2'd2: v = am >> 1;
      default: v = am;
    endcase
    for (int k = 0; k < 4; k++) r[k] = (en && m[k]) ? v : 7'd0;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one sample strobe, expectation pushed for the monitor
  task automatic drive(logic en, logic [31:0] st, logic [1:0] s, logic [3:0] m, string tag);
    exp_t e;
    @(negedge clk_i);
    enable_i = en; step_i = st; ams_i = s; am_mask_i = m; sample_i = 1'b1;
    if (en) m_cnt = m_cnt + st;
    e.am  = m_am(m_cnt[31:25]);
    e.pm  = m_cnt[31:27];
    e.ofs = m_ofs(e.am, en, s, m);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk_i);
    sample_i = 1'b0;
    @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      if (sample_i && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        @(negedge clk_i);
        chk({e.tag, " am"}, 32'(am_o), 32'(e.am));
        chk({e.tag, " pm"}, 32'(pm_o), 32'(e.pm));
        chk({e.tag, " ofs"}, 32'(am_ofs_o), 32'(e.ofs));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset am", 32'(am_o), 0);
    chk("R1 reset pm", 32'(pm_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    enable_i = 1'b1; ams_i = 2'd3; am_mask_i = 4'hF;
    #1 chk("R1 reset ofs", 32'(am_ofs_o), 0);

    // R10: no strobe, nothing changes
    repeat (4) @(negedge clk_i);
    chk("R10 idle am", 32'(am_o), 0);

    // R2 R3 R4 R9: one index per sample through the wrap
    for (int i = 0; i < 132; i++) drive(1'b1, 32'h0200_0000, 2'd3, 4'hF, "R3 R4 R9 walk");
    // R2: sub-index step leaves the index alone
    for (int i = 0; i < 6; i++) drive(1'b1, 32'h0000_4000, 2'd2, 4'h5, "R2 small");
    // R4: large steps skipping indices
    for (int i = 0; i < 10; i++) drive(1'b1, 32'h1350_0000, 2'd1, 4'hA, "R4 big");
    // R5 R8: disabled strobes freeze the counter
    for (int i = 0; i < 5; i++) drive(1'b0, 32'h0F00_0000, 2'd3, 4'hF, "R5 R8 off");
    drive(1'b1, 32'h0200_0000, 2'd3, 4'hF, "R5 resume");
    // R6 R7: every sensitivity with mixed masks
    for (int s = 0; s < 4; s++) begin
      drive(1'b1, 32'h0A00_0000, 2'(s), 4'b0110, "R6 R7 ams");
      drive(1'b1, 32'h0600_0000, 2'(s), 4'b1001, "R6 R7 ams");
    end

    // R8: enable drop at the port, no strobe
    @(negedge clk_i);
    enable_i = 1'b0; am_mask_i = 4'hF; ams_i = 2'd3;
    #1 chk("R8 disabled ofs", 32'(am_ofs_o), 0);
    @(negedge clk_i);
    enable_i = 1'b1; am_mask_i = 4'b0000;
    #1 chk("R7 masked ofs", 32'(am_ofs_o), 0);

    repeat (3) @(negedge clk_i);
    chk("R2 queue drained", 32'(q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule